// File: doc/BRIEF.md
# Two-Channel Tamper Detector with Level Filter

This block watches two tamper inputs of an always-powered domain and holds a bank of twenty 32-bit retained words. Each input is gated by its own enable. A shared 2-bit filter field selects the detection style. In edge style an input fires on its active edge, which is rising or falling per channel. In filtered style the input is sampled at a programmable rate and fires once enough consecutive samples show the active level.

In filtered style a pull-up enable output is asserted for a short precharge window before each sample point, unless the pull-up is disabled. A detection sets that channel's sticky flag and wipes every retained word in the same clock. It can also request a timestamp capture, and it raises an interrupt while a flag is set and interrupts are enabled. Software reads and writes the retained words through a simple synchronous port. Flags are cleared with a write-one-to-clear pulse.

Top module: `tamper_guard`

## Requirements
- R1: Each channel has its own enable and its own sticky flag (`tamp_flag[i]`). A disabled channel never sets its flag. A `flag_clr[i]` pulse clears the flag on the next clock edge unless a detection on that channel happens in the same cycle, in which case the flag stays set.
- R2: With `filt_sel` = 00 (edge style), the active level of channel i is high when `trig_fall[i]`=0 and low when `trig_fall[i]`=1. The flag sets on the clock edge at which the input is first sampled at its active level after being inactive. An input held at its active level does not fire again after its flag is cleared.
- R3: In edge style, a channel whose input already sits at its active level when its enable rises fires on the first clock edge with the enable high, without a new edge.
- R4: With `filt_sel` = 01, 10 or 11, a channel fires at the sample where its active level has been seen on 2, 4 or 8 consecutive samples. Any inactive sample restarts the count from zero.
- R5: In filtered style the sample period is 2^(15-`rate_sel`) clock cycles. After the clock edge that first sees a nonzero `filt_sel`, counted as edge 1, samples fall on edges P, 2P, 3P and so on. A channel that needs N samples at period P therefore sets its flag on edge N*P.
- R6: `pullup_en` is high only in filtered style, with at least one channel enabled and `pu_disable`=0. It is high during the last 2^`prech_sel` cycles of each sample period, counting the sample cycle, and it is never high in edge style.
- R7: The retained bank has 20 words at addresses 0 to 19. A write is stored when `bkp_we`=1 and is read back combinationally on `bkp_rdata`. Writes to addresses 20 and above are dropped, and reads there return 0. Any detection on either channel clears all 20 words on the edge that sets the flag, taking priority over a write in that cycle.
- R8: When `ts_on_tamp`=1, `ts_req` is a one-cycle pulse in the same cycle a flag becomes set by a detection. When `ts_on_tamp`=0, `ts_req` stays low.
- R9: `irq` is high whenever `irq_en`=1 and any flag is set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tamp_pin | input | 2 | Tamper inputs |
| chan_en | input | 2 | Per-channel enable |
| trig_fall | input | 2 | Per-channel active level: 0 high/rising, 1 low/falling |
| filt_sel | input | 2 | 00 edge style, 01/10/11 need 2/4/8 samples |
| rate_sel | input | 3 | Sample period 2^(15-n) cycles |
| prech_sel | input | 2 | Precharge length 2^n cycles |
| pu_disable | input | 1 | Suppresses the pull-up enable |
| ts_on_tamp | input | 1 | Detection also requests a timestamp |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 2 | Write-one-to-clear pulse per flag |
| bkp_we | input | 1 | Retained bank write strobe |
| bkp_addr | input | 5 | Retained bank word address |
| bkp_wdata | input | 32 | Retained bank write data |
| bkp_rdata | output | 32 | Retained bank read data |
| tamp_flag | output | 2 | Sticky detection flags |
| irq | output | 1 | Interrupt |
| ts_req | output | 1 | Timestamp capture request pulse |
| pullup_en | output | 1 | Pull-up enable for precharge |

## Verification
The bench aims at enabling a channel whose input already sits at its active level. A design that waits for a genuine edge would miss that detection. It also holds an input active after its flag is cleared, which catches a design that treats a level as a fresh event. In filtered style the bench checks the flag one cycle before and exactly at the N*P boundary, so an off-by-one sample counter or a wrong period is caught. It also drops the input across exactly one sample point, which catches a filter that counts active samples instead of consecutive ones. The pull-up window is checked at its first cycle, with the pull-up disable set, and in edge style. The retained bank is checked for a wipe on every kind of detection and for writes beyond word 19 being dropped.

// File: rtl/tamper_pkg.sv
package tamper_pkg;

  // consecutive active samples required by a filter code (0 = edge style)
  function automatic logic [3:0] samples_needed(input logic [1:0] code);
    case (code)
      2'b01:   samples_needed = 4'd2;
      2'b10:   samples_needed = 4'd4;
      2'b11:   samples_needed = 4'd8;
      default: samples_needed = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/tamper_timebase.sv
module tamper_timebase #(
  parameter int CNT_W  = 15,
  parameter int RATE_W = 3,
  parameter int PRE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              level_mode,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [PRE_W-1:0]  prech_sel,
  output logic              tick,
  output logic              prech_win
);
  localparam int PW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PW-1:0]    period, dur;
  logic             last;

  always_comb begin
    period    = PW'(1) << (CNT_W - int'(rate_sel));
    dur       = PW'(1) << prech_sel;
    last      = ({1'b0, cnt_q} == period - PW'(1));
    tick      = level_mode & last;
    prech_win = level_mode & ({1'b0, cnt_q} >= period - dur);
    if (!level_mode || last) cnt_d = '0;
    else                     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: sample strobes only exist in filtered style, and the count stays inside one period
  a_r5_tick_level_only: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> level_mode);
  a_r5_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_q} < period));
endmodule

// File: rtl/tamper_channel.sv
module tamper_channel
  import tamper_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic       en,
  input  logic       trig_fall,
  input  logic [1:0] filt_sel,
  input  logic       tick,
  input  logic       clr,
  output logic       hit,
  output logic       flag
);
  logic       act, level, edge_hit, lvl_hit;
  logic       prev_q, prev_d;
  logic [3:0] need, run_q, run_d;
  logic       flag_q, flag_d;

  always_comb begin
    act      = pin ^ trig_fall;
    level    = |filt_sel;
    need     = samples_needed(filt_sel);
    prev_d   = en & act;
    edge_hit = ~level & en & act & ~prev_q;
    lvl_hit  = level & en & tick & act & (run_q + 4'd1 == need);
    run_d    = run_q;
    if (!level || !en)   run_d = '0;
    else if (tick) begin
      if (!act)               run_d = '0;
      else if (run_q < need)  run_d = run_q + 4'd1;
    end
    hit    = edge_hit | lvl_hit;
    flag_d = (flag_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  // R1: a set flag only drops on a clear pulse; a disabled channel never fires
  a_r1_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !hit);
  // R2: an edge-style detection needs the active level on the pin
  a_r2_edge_active: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !level) |-> act);
  // R4: the consecutive-sample count never exceeds the largest filter depth
  a_r4_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 4'd8);
endmodule

// File: rtl/tamper_backup.sv
module tamper_backup #(
  parameter int WORDS = 20,
  parameter int DW    = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [WORDS];
  logic [DW-1:0] mem_d [WORDS];
  logic          in_range;

  always_comb begin
    in_range = (int'(addr) < WORDS);
    for (int i = 0; i < WORDS; i++) begin
      if (wipe)                                mem_d[i] = '0;
      else if (we && in_range && int'(addr) == i) mem_d[i] = wdata;
      else                                     mem_d[i] = mem_q[i];
    end
    rdata = '0;
    for (int i = 0; i < WORDS; i++)
      if (int'(addr) == i) rdata = mem_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= mem_d[i];
    end
  end

  // R7: a wipe leaves the first and last words empty on the next cycle
  a_r7_wipe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (mem_q[0] == '0 && mem_q[WORDS-1] == '0));
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard #(
  parameter int NCH   = 2,
  parameter int WORDS = 20,
  parameter int DW    = 32,
  parameter int AW    = 5,
  parameter int CNT_W = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tamp_pin,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] trig_fall,
  input  logic [1:0]     filt_sel,
  input  logic [2:0]     rate_sel,
  input  logic [1:0]     prech_sel,
  input  logic           pu_disable,
  input  logic           ts_on_tamp,
  input  logic           irq_en,
  input  logic [NCH-1:0] flag_clr,
  input  logic           bkp_we,
  input  logic [AW-1:0]  bkp_addr,
  input  logic [DW-1:0]  bkp_wdata,
  output logic [DW-1:0]  bkp_rdata,
  output logic [NCH-1:0] tamp_flag,
  output logic           irq,
  output logic           ts_req,
  output logic           pullup_en
);
  logic           level_mode, tick, prech_win, any_hit;
  logic [NCH-1:0] hit;
  logic           ts_q, ts_d;

  assign level_mode = |filt_sel;

  tamper_timebase #(.CNT_W(CNT_W), .RATE_W(3), .PRE_W(2)) u_tb (
    .clk(clk), .rst_n(rst_n), .level_mode(level_mode),
    .rate_sel(rate_sel), .prech_sel(prech_sel),
    .tick(tick), .prech_win(prech_win)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tamper_channel u_ch (
      .clk(clk), .rst_n(rst_n), .pin(tamp_pin[c]), .en(chan_en[c]),
      .trig_fall(trig_fall[c]), .filt_sel(filt_sel), .tick(tick),
      .clr(flag_clr[c]), .hit(hit[c]), .flag(tamp_flag[c])
    );
  end

  tamper_backup #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_bkp (
    .clk(clk), .rst_n(rst_n), .wipe(any_hit), .we(bkp_we),
    .addr(bkp_addr), .wdata(bkp_wdata), .rdata(bkp_rdata)
  );

  always_comb begin
    any_hit   = |hit;
    ts_d      = ts_on_tamp & any_hit;
    irq       = irq_en & (|tamp_flag);
    pullup_en = prech_win & (|chan_en) & ~pu_disable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= 1'b0;
    else        ts_q <= ts_d;
  end
  assign ts_req = ts_q;

  // R6: no pull-up drive in edge style or when disabled
  a_r6_pullup_edge_off: assert property (@(posedge clk) disable iff (!rst_n)
    !level_mode |-> !pullup_en);
  a_r6_pullup_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    pu_disable |-> !pullup_en);
  // R7: after any detection the addressed word reads empty
  a_r7_bank_empty: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> (bkp_rdata == '0));
  // R8: a timestamp request always coincides with a set flag
  a_r8_ts_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ts_req |-> (|tamp_flag));
  a_r8_ts_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_req && !ts_d) |=> !ts_req);
  // R9: a newly set flag with interrupts enabled raises the interrupt
  a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tamp_flag[0]) && irq_en) |-> irq);
endmodule

// File: tb/tamper_guard_test.sv
module tamper_guard_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  tamp_pin, chan_en, trig_fall, filt_sel, prech_sel, flag_clr;
  logic [2:0]  rate_sel;
  logic        pu_disable, ts_on_tamp, irq_en, bkp_we;
  logic [4:0]  bkp_addr;
  logic [31:0] bkp_wdata, bkp_rdata;
  logic [1:0]  tamp_flag;
  logic        irq, ts_req, pullup_en;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  tamper_guard uut (
    .clk(clk), .rst_n(rst_n), .tamp_pin(tamp_pin), .chan_en(chan_en),
    .trig_fall(trig_fall), .filt_sel(filt_sel), .rate_sel(rate_sel),
    .prech_sel(prech_sel), .pu_disable(pu_disable), .ts_on_tamp(ts_on_tamp),
    .irq_en(irq_en), .flag_clr(flag_clr), .bkp_we(bkp_we), .bkp_addr(bkp_addr),
    .bkp_wdata(bkp_wdata), .bkp_rdata(bkp_rdata), .tamp_flag(tamp_flag),
    .irq(irq), .ts_req(ts_req), .pullup_en(pullup_en)
  );

  always #4 clk = ~clk;

  function automatic int need_of(input logic [1:0] f);
    return (f == 2'b01) ? 2 : (f == 2'b10) ? 4 : (f == 2'b11) ? 8 : 0;
  endfunction
  function automatic int period_of(input logic [2:0] r);
    return 1 << (15 - int'(r));
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // k clock edges, then sample/drive 2 ns after the last one
  task automatic step(input int k);
    repeat (k) @(posedge clk);
    #2;
  endtask

  task automatic quiesce();
    chan_en = 2'b00; filt_sel = 2'b00; flag_clr = 2'b11; bkp_we = 1'b0;
    step(2);
    flag_clr = 2'b00;
    step(1);
  endtask

  task automatic bkp_write(input logic [4:0] a, input logic [31:0] d);
    bkp_addr = a; bkp_wdata = d; bkp_we = 1'b1;
    step(1);
    bkp_we = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [1:0] m_flag, m_prev;
    int p, n;
    void'($urandom(32'd2024));
    rst_n = 1'b0; tamp_pin = 0; chan_en = 0; trig_fall = 0; filt_sel = 0;
    rate_sel = 3'd7; prech_sel = 0; pu_disable = 0; ts_on_tamp = 1; irq_en = 1;
    flag_clr = 0; bkp_we = 0; bkp_addr = 0; bkp_wdata = 0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // reset state (R1, R9, R8, R6, R7)
    chk(tamp_flag, 0, "R1 reset flags");
    chk(irq, 0, "R9 reset irq");
    chk(ts_req, 0, "R8 reset ts_req");
    chk(pullup_en, 0, "R6 reset pullup");
    chk(bkp_rdata, 0, "R7 reset bank");

    // R7 bank read/write and out-of-range
    bkp_write(5'd0, 32'hA5A5_0001);
    bkp_write(5'd19, 32'h1234_5678);
    bkp_write(5'd25, 32'hDEAD_BEEF);
    bkp_addr = 5'd0;  #1; chk(bkp_rdata, 32'hA5A5_0001, "R7 word0");
    bkp_addr = 5'd19; #1; chk(bkp_rdata, 32'h1234_5678, "R7 word19");
    bkp_addr = 5'd25; #1; chk(bkp_rdata, 0, "R7 addr25 reads zero");

    // R2 rising edge on ch0, with R7 wipe, R8 pulse, R9 irq
    chan_en = 2'b01; step(2);
    chk(tamp_flag, 0, "R2 no flag at inactive level");
    tamp_pin[0] = 1'b1;
    step(1);
    chk(tamp_flag, 2'b01, "R2 rising edge sets flag0");
    chk(ts_req, 1, "R8 ts_req with flag");
    chk(irq, 1, "R9 irq with flag");
    bkp_addr = 5'd19; #1;
    chk(bkp_rdata, 0, "R7 wipe word19");
    step(1);
    chk(ts_req, 0, "R8 ts_req one cycle");

    // R2 held level after clear: no refire
    flag_clr = 2'b01; step(1); flag_clr = 2'b00;
    step(4);
    chk(tamp_flag, 0, "R2 held level no refire");
    chk(irq, 0, "R9 irq low with no flag");

    // R2 falling edge on ch1, R8 gating off, R9 irq disabled
    ts_on_tamp = 1'b0; irq_en = 1'b0;
    trig_fall[1] = 1'b1; tamp_pin[1] = 1'b1; chan_en = 2'b11;
    step(2);
    chk(tamp_flag, 0, "R2 ch1 high is inactive when falling");
    tamp_pin[1] = 1'b0;
    step(1);
    chk(tamp_flag, 2'b10, "R2 falling edge sets flag1 only");
    chk(ts_req, 0, "R8 ts_req gated off");
    chk(irq, 0, "R9 irq disabled");
    ts_on_tamp = 1'b1; irq_en = 1'b1;

    // R3 enable with input already active
    quiesce();
    trig_fall = 2'b00; tamp_pin = 2'b01;
    step(3);
    chk(tamp_flag, 0, "R1 disabled channel stays quiet");
    chan_en = 2'b01;
    step(1);
    chk(tamp_flag, 2'b01, "R3 immediate detection on enable");

    // R1 event wins over clear in same cycle
    quiesce();
    tamp_pin = 2'b00; chan_en = 2'b01; step(1);
    tamp_pin[0] = 1'b1; flag_clr = 2'b01;
    step(1);
    flag_clr = 2'b00;
    chk(tamp_flag, 2'b01, "R1 detection beats clear");

    // R4/R5/R6 level mode 2 samples, P=256, precharge 4
    quiesce();
    tamp_pin = 2'b01; trig_fall = 2'b00;
    bkp_write(5'd7, 32'hCAFE_F00D);
    filt_sel = 2'b01; rate_sel = 3'd7; prech_sel = 2'd2; pu_disable = 1'b0;
    chan_en = 2'b01;
    p = period_of(3'd7); n = need_of(2'b01);
    step(p - 4 - 1);
    chk(pullup_en, 0, "R6 before precharge window");
    step(1);
    chk(pullup_en, 1, "R6 precharge window start");
    step(n * p - 1 - (p - 4));
    chk(tamp_flag, 0, "R5 flag not yet at N*P-1");
    bkp_addr = 5'd7; #1;
    chk(bkp_rdata, 32'hCAFE_F00D, "R7 word kept before event");
    step(1);
    chk(tamp_flag, 2'b01, "R4 two samples set flag0");
    chk(ts_req, 1, "R8 ts_req on level event");
    chk(bkp_rdata, 0, "R7 level event wipes bank");

    // R4 inactive sample restarts count, 4 samples
    quiesce();
    tamp_pin = 2'b01; filt_sel = 2'b10; chan_en = 2'b01;
    step(2 * p + 100);
    tamp_pin[0] = 1'b0;
    step(p);
    tamp_pin[0] = 1'b1;
    step(4 * p - (3 * p + 100));
    chk(tamp_flag, 0, "R4 count restarted by inactive sample");
    step(7 * p - 1 - 4 * p);
    chk(tamp_flag, 0, "R4 flag not yet at restart+3 samples");
    step(1);
    chk(tamp_flag, 2'b01, "R4 four consecutive samples");

    // R4/R5/R6 ch1 active-low, 8 samples, P=512, pull-up disabled
    quiesce();
    trig_fall = 2'b10; tamp_pin = 2'b00;
    filt_sel = 2'b11; rate_sel = 3'd6; prech_sel = 2'd0; pu_disable = 1'b1;
    chan_en = 2'b10;
    p = period_of(3'd6); n = need_of(2'b11);
    step(p - 1);
    chk(pullup_en, 0, "R6 pull-up disabled in window");
    step(n * p - 1 - (p - 1));
    chk(tamp_flag, 0, "R5 flag not yet at 8P-1");
    step(1);
    chk(tamp_flag, 2'b10, "R5 eight samples at P=512 set flag1");

    // random edge-style traffic against a model (R1, R2, R3)
    quiesce();
    rate_sel = 3'd7; pu_disable = 1'b0;
    m_flag = 2'b00; m_prev = 2'b00;
    for (int i = 0; i < 300; i++) begin
      tamp_pin  = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) chan_en   = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) trig_fall = 2'($urandom_range(0, 3));
      flag_clr  = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      begin
        logic [1:0] act, ev;
        act    = tamp_pin ^ trig_fall;
        ev     = chan_en & act & ~m_prev;
        m_prev = chan_en & act;
        m_flag = (m_flag & ~flag_clr) | ev;
      end
      step(1);
      chk(tamp_flag, m_flag, "R2 random edge traffic");
      chk(pullup_en, 0, "R6 edge style pull-up off");
    end
    flag_clr = 2'b00;

    done = 1;
    summary();
  end
endmodule